// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This block adds or subtracts two signed packed decimal numbers of independent lengths, one byte per clock, and writes a signed result sized to the first operand. Each operand arrives as a 16-byte buffer with a 4-bit length field. Every byte holds two decimal digits. The exception is the least significant byte, whose low nibble carries the sign. The caller raises `start` for one cycle. The unit latches the operands, checks them and runs the arithmetic. It then raises `done` for one cycle, with the result and two flags: a data exception and a decimal overflow.

When the effective signs agree, the unit adds magnitudes. When they differ, it adds the ten's complement of the second magnitude. If that subtraction has no end carry, the true difference is negative. The unit then spends a second byte-serial pass re-complementing the result and flips the sign. Operands are processed from the least significant byte upward. The shorter operand is padded with zero digits.

Top module: `dec_addsub`

## Requirements
- R1: Digit j (j = 0 is least significant) of an operand of L bytes sits in bits [4(j+1)+3 : 4(j+1)], for j from 0 to 2L-2. The sign is in bits [3:0]. A length field holds L-1, so 0 means one byte and 15 means sixteen.
- R2: With `sub_op` = 0 the operands are added. With `sub_op` = 1 the sign of the second operand is inverted first. When the resulting signs agree, the magnitudes are added and the first operand's sign is kept.
- R3: When the effective signs differ, the result is the difference of the magnitudes with the sign of the larger one. Equal magnitudes give zero.
- R4: Sign codes 4'hB and 4'hD read as negative. Codes 4'hA, 4'hC, 4'hE and 4'hF read as positive.
- R5: A result sign is always 4'hC (positive) or 4'hD (negative). A result whose kept digits are all zero always carries 4'hC.
- R6: A digit nibble above 9, or a sign nibble below 4'hA, in either operand within its length raises `data_exc`. In that case `res_bytes` is all zeros and `dec_ovf` is 0.
- R7: Nibbles in bytes at or beyond an operand's length are neither checked nor used.
- R8: A magnitude that needs more than 2L1-1 digits raises `dec_ovf` and keeps only the low-order digits. Result bytes at or beyond L1 are always zero.
- R9: With the start edge counted as cycle 0, `done` is high for exactly one cycle. It rises after cycle 2 for a data exception. Otherwise it rises after cycle 2+N, where N is the larger of the two lengths in bytes. When the subtraction of magnitudes comes out negative, it rises after cycle 2+2N instead.
- R10: `start` is ignored while an operation is in progress. `res_bytes`, `data_exc` and `dec_ovf` change only in the cycle in which `done` is high.
- R11: Reset clears `done`, `data_exc`, `dec_ovf` and `res_bytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| sub_op | input | 1 | 1 selects subtraction |
| opa_bytes | input | 128 | First operand, byte 0 least significant |
| opa_len_m1 | input | 4 | First operand length minus one |
| opb_bytes | input | 128 | Second operand, byte 0 least significant |
| opb_len_m1 | input | 4 | Second operand length minus one |
| res_bytes | output | 128 | Signed packed result in the first operand's length |
| done | output | 1 | One-cycle completion pulse |
| data_exc | output | 1 | Invalid digit or sign seen |
| dec_ovf | output | 1 | Result did not fit |

## Verification
A corrupted carry or digit register shows up as a wrong result byte at the `done` pulse that ends the same operation. A mis-sequenced state or byte counter shows up as `done` arriving a cycle early or late. That slip is visible at the ports as soon as the expected completion cycle passes. A wrong complement decision changes both the latency (one pass versus two) and the result sign. The bench therefore predicts the completion cycle of every operation and compares `done` and every output on every clock. It uses wide-integer arithmetic on the decimal values, so a single wrong digit or a single wrong cycle is reported at once.

// File: rtl/dec_pkg.sv
// Shared constants and types for the packed decimal add/subtract unit.
// Assumes one byte carries two BCD digits, with the sign in the low nibble of byte 0.
package dec_pkg;
    localparam logic [3:0] SIGN_POS = 4'hC;
    localparam logic [3:0] SIGN_NEG = 4'hD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SUM,
        ST_FIX,
        ST_FINISH
    } dec_state_e;

    // True for the two sign codes that denote a negative value.
    function automatic logic sign_is_neg(input logic [3:0] code);
        return (code == 4'hB) || (code == 4'hD);
    endfunction
endpackage

// File: rtl/dec_digit_add.sv
// One BCD digit adder: x + y + cin with a decimal carry.
// Assumes x and y are each in 0..9, so the raw sum never exceeds 19.
module dec_digit_add (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       cin,
    output logic [3:0] d,
    output logic       cout
);
    logic [4:0] raw;
    logic [4:0] adj;

    // Binary sum, then a decimal correction when it passes nine.
    always_comb begin
        raw  = {1'b0, x} + {1'b0, y} + {4'd0, cin};
        adj  = raw - 5'd10;
        cout = (raw > 5'd9);
        d    = cout ? adj[3:0] : raw[3:0];
    end
endmodule

// File: rtl/dec_byte_add.sv
// Adds one packed byte (two digits), optionally taking the nines complement of y.
// When skip_lo is set, the low nibble is a sign. The carry then bypasses it, and the low result nibble is zero.
module dec_byte_add (
    input  logic [7:0] x_byte,
    input  logic [7:0] y_byte,
    input  logic       inv_y,
    input  logic       skip_lo,
    input  logic       cin,
    output logic [7:0] s_byte,
    output logic       cout
);
    logic [3:0] y_lo, y_hi, d_lo, d_hi;
    logic       c_lo, c_mid;

    // Select the plain or nines-complemented second digit pair.
    always_comb begin
        y_lo = inv_y ? (4'd9 - y_byte[3:0]) : y_byte[3:0];
        y_hi = inv_y ? (4'd9 - y_byte[7:4]) : y_byte[7:4];
    end

    dec_digit_add u_lo (.x(x_byte[3:0]), .y(y_lo), .cin(cin),   .d(d_lo), .cout(c_lo));
    dec_digit_add u_hi (.x(x_byte[7:4]), .y(y_hi), .cin(c_mid), .d(d_hi), .cout(cout));

    // Route the carry around a sign nibble and assemble the sum byte.
    always_comb begin
        c_mid  = skip_lo ? cin : c_lo;
        s_byte = {d_hi, skip_lo ? 4'h0 : d_lo};
    end
endmodule

// File: rtl/dec_operand_check.sv
// Validity check and sign decode for one packed operand.
// Only nibbles inside the operand's length are examined; nibble 0 is the sign.
module dec_operand_check #(
    parameter int MAX_BYTES = 16,
    localparam int LEN_W    = $clog2(MAX_BYTES),
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic [DATA_W-1:0] bytes_in,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              bad,
    output logic              neg
);
    localparam int NIBS = 2 * MAX_BYTES;
    logic [NIBS-1:0] bad_vec;

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        localparam logic [LEN_W-1:0] BYTE_IX = LEN_W'(n / 2);
        if (n == 0) begin : g_sign
            // A sign code must lie in A..F.
            assign bad_vec[n] = (bytes_in[3:0] < 4'hA);
        end else begin : g_digit
            // A digit inside the length must lie in 0..9.
            assign bad_vec[n] = (BYTE_IX <= len_m1) && (bytes_in[n*4 +: 4] > 4'd9);
        end
    end

    assign bad = |bad_vec;
    assign neg = dec_pkg::sign_is_neg(bytes_in[3:0]);
endmodule

// File: rtl/dec_addsub.sv
// Byte-serial signed packed decimal add/subtract; the result takes the first operand's length.
// Assumes start is a single-cycle strobe; it is ignored unless the unit is idle.
module dec_addsub #(
    parameter int MAX_BYTES = 16,
    localparam int LEN_W    = $clog2(MAX_BYTES),
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sub_op,
    input  logic [DATA_W-1:0] opa_bytes,
    input  logic [LEN_W-1:0]  opa_len_m1,
    input  logic [DATA_W-1:0] opb_bytes,
    input  logic [LEN_W-1:0]  opb_len_m1,
    output logic [DATA_W-1:0] res_bytes,
    output logic              done,
    output logic              data_exc,
    output logic              dec_ovf
);
    import dec_pkg::*;

    dec_state_e        st;
    logic [DATA_W-1:0] a_q, b_q, acc;
    logic [LEN_W-1:0]  la_q, lb_q, idx;
    logic              sub_q, neg_a_q, diff_q, carry_q, fixed_q, exc_q;

    logic [DATA_W-1:0] a_pad, b_pad, res_next;
    logic [LEN_W-1:0]  n_last;
    logic              bad_a, bad_b, neg_a, neg_b, eff_diff;
    logic [7:0]        add_x, add_y, add_s;
    logic              add_inv, add_cout, fix_phase;
    logic              beyond_nz, kept_zero, res_neg, ovf_next;

    dec_operand_check #(.MAX_BYTES(MAX_BYTES)) u_chk_a (
        .bytes_in(a_q), .len_m1(la_q), .bad(bad_a), .neg(neg_a));
    dec_operand_check #(.MAX_BYTES(MAX_BYTES)) u_chk_b (
        .bytes_in(b_q), .len_m1(lb_q), .bad(bad_b), .neg(neg_b));

    // Zero the bytes beyond each operand's length and find the last byte to process.
    always_comb begin
        for (int k = 0; k < MAX_BYTES; k++) begin
            a_pad[k*8 +: 8] = (k <= int'(la_q)) ? a_q[k*8 +: 8] : 8'h00;
            b_pad[k*8 +: 8] = (k <= int'(lb_q)) ? b_q[k*8 +: 8] : 8'h00;
        end
        n_last   = (la_q > lb_q) ? la_q : lb_q;
        eff_diff = neg_a ^ neg_b ^ sub_q;
    end

    // Adder operands: magnitude pass, or re-complement pass over the accumulator.
    always_comb begin
        fix_phase = (st == ST_FIX);
        add_x     = fix_phase ? 8'h00 : a_pad[int'(idx)*8 +: 8];
        add_y     = fix_phase ? acc[int'(idx)*8 +: 8] : b_pad[int'(idx)*8 +: 8];
        add_inv   = fix_phase | diff_q;
    end

    dec_byte_add u_add (
        .x_byte(add_x), .y_byte(add_y), .inv_y(add_inv),
        .skip_lo(idx == '0), .cin(carry_q),
        .s_byte(add_s), .cout(add_cout));

    // Truncate to the first length, decide overflow and choose the result sign.
    always_comb begin
        beyond_nz = 1'b0;
        res_next  = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k <= int'(la_q)) res_next[k*8 +: 8] = acc[k*8 +: 8];
            else if (acc[k*8 +: 8] != 8'h00) beyond_nz = 1'b1;
        end
        res_next[3:0] = 4'h0;
        kept_zero     = (res_next == '0);
        res_neg       = fixed_q ? ~neg_a_q : neg_a_q;
        res_next[3:0] = (kept_zero || !res_neg) ? SIGN_POS : SIGN_NEG;
        ovf_next      = beyond_nz | (~diff_q & carry_q);
    end

    // Sequencer: latch, check, serial sum, optional re-complement, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            a_q       <= '0;
            b_q       <= '0;
            acc       <= '0;
            la_q      <= '0;
            lb_q      <= '0;
            idx       <= '0;
            sub_q     <= 1'b0;
            neg_a_q   <= 1'b0;
            diff_q    <= 1'b0;
            carry_q   <= 1'b0;
            fixed_q   <= 1'b0;
            exc_q     <= 1'b0;
            res_bytes <= '0;
            done      <= 1'b0;
            data_exc  <= 1'b0;
            dec_ovf   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        a_q     <= opa_bytes;
                        b_q     <= opb_bytes;
                        la_q    <= opa_len_m1;
                        lb_q    <= opb_len_m1;
                        sub_q   <= sub_op;
                        acc     <= '0;
                        exc_q   <= 1'b0;
                        fixed_q <= 1'b0;
                        st      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    neg_a_q <= neg_a;
                    diff_q  <= eff_diff;
                    carry_q <= eff_diff;
                    idx     <= '0;
                    if (bad_a || bad_b) begin
                        exc_q <= 1'b1;
                        st    <= ST_FINISH;
                    end else begin
                        st    <= ST_SUM;
                    end
                end
                ST_SUM: begin
                    acc[int'(idx)*8 +: 8] <= add_s;
                    carry_q               <= add_cout;
                    idx                   <= idx + 1'b1;
                    if (idx == n_last) begin
                        if (diff_q && !add_cout) begin
                            idx     <= '0;
                            carry_q <= 1'b1;
                            fixed_q <= 1'b1;
                            st      <= ST_FIX;
                        end else begin
                            st      <= ST_FINISH;
                        end
                    end
                end
                ST_FIX: begin
                    acc[int'(idx)*8 +: 8] <= add_s;
                    carry_q               <= add_cout;
                    idx                   <= idx + 1'b1;
                    if (idx == n_last) st <= ST_FINISH;
                end
                ST_FINISH: begin
                    done     <= 1'b1;
                    data_exc <= exc_q;
                    dec_ovf  <= exc_q ? 1'b0 : ovf_next;
                    res_bytes <= exc_q ? '0 : res_next;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dec_addsub_chk.sv
// Port-level properties of dec_addsub, attached by bind.
// Assumes reset is held for at least three cycles at power-up.
module dec_addsub_chk #(
    parameter int MAX_BYTES = 16,
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] res_bytes,
    input logic              done,
    input logic              data_exc,
    input logic              dec_ovf
);
    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: outputs move only together with the completion pulse.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_bytes) && $stable(data_exc) && $stable(dec_ovf)));

    // R6: a data exception suppresses the result and the overflow flag.
    p_exc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_exc) |-> (res_bytes == '0 && !dec_ovf));

    // R5: only the two preferred sign codes are produced.
    p_sign_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !data_exc) |-> (res_bytes[3:0] == 4'hC || res_bytes[3:0] == 4'hD));

    // R5: a zero magnitude always carries the positive code.
    p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !data_exc && (res_bytes[DATA_W-1:4] == '0)) |-> (res_bytes[3:0] == 4'hC));
endmodule

bind dec_addsub dec_addsub_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_bytes(res_bytes),
    .done(done), .data_exc(data_exc), .dec_ovf(dec_ovf));

// File: tb/sim_dec_addsub.sv
// Bench for dec_addsub. Expected values come from wide-integer decimal arithmetic.
// Every clock, done and the outputs are compared against the predicted completion cycle.
module sim_dec_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int MB = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub_op = 1'b0;
    logic [127:0] opa_bytes = '0, opb_bytes = '0;
    logic [3:0]   opa_len_m1 = '0, opb_len_m1 = '0;
    logic [127:0] res_bytes;
    logic         done, data_exc, dec_ovf;

    int checks = 0;
    int fails  = 0;
    logic [127:0] held_res = '0;
    logic         held_exc = 1'b0, held_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_addsub #(.MAX_BYTES(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
        .opa_bytes(opa_bytes), .opa_len_m1(opa_len_m1),
        .opb_bytes(opb_bytes), .opb_len_m1(opb_len_m1),
        .res_bytes(res_bytes), .done(done), .data_exc(data_exc), .dec_ovf(dec_ovf));

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pow10(input int n);
        logic [127:0] p = 128'd1;
        for (int i = 0; i < n; i++) p = p * 128'd10;
        return p;
    endfunction

    // Build a packed operand: digit j goes to nibble j+1 (R1).
    function automatic logic [127:0] mk(input logic [127:0] v, input int len_m1, input logic [3:0] sgn);
        logic [127:0] b = '0;
        logic [127:0] r = v;
        b[3:0] = sgn;
        for (int j = 0; j < 2*(len_m1+1)-1; j++) begin
            b[(j+1)*4 +: 4] = 4'(r % 128'd10);
            r = r / 128'd10;
        end
        return b;
    endfunction

    function automatic logic [127:0] value_of(input logic [127:0] b, input int len_m1);
        logic [127:0] v = '0;
        for (int j = 2*(len_m1+1)-2; j >= 0; j--) v = v * 128'd10 + 128'(b[(j+1)*4 +: 4]);
        return v;
    endfunction

    function automatic logic invalid(input logic [127:0] b, input int len_m1);
        logic bad = (b[3:0] < 4'hA);
        for (int j = 0; j < 2*(len_m1+1)-1; j++) if (b[(j+1)*4 +: 4] > 4'd9) bad = 1'b1;
        return bad;
    endfunction

    // One operation: predict result and completion cycle, then compare every clock.
    task automatic run_op(input logic [127:0] a, input int la, input logic [127:0] b, input int lb,
                          input logic sub, input logic busy_poke, input string tag);
        logic sa, sb, exc, negres, ovf;
        logic [127:0] va, vb, m, lim, eres;
        int n, lat;
        exc = invalid(a, la) || invalid(b, lb);
        sa  = (a[3:0] == 4'hB) || (a[3:0] == 4'hD);
        sb  = ((b[3:0] == 4'hB) || (b[3:0] == 4'hD)) ^ sub;
        va  = value_of(a, la);
        vb  = value_of(b, lb);
        n   = ((la > lb) ? la : lb) + 1;
        lat = 2 + n;
        if (sa == sb) begin m = va + vb; negres = sa; end
        else if (va >= vb) begin m = va - vb; negres = sa; end
        else begin m = vb - va; negres = !sa; lat = 2 + 2*n; end
        lim = pow10(2*(la+1)-1);
        ovf = (m >= lim);
        m   = m % lim;
        eres = mk(m, la, (m == 0 || !negres) ? 4'hC : 4'hD);
        if (exc) begin lat = 2; eres = '0; ovf = 1'b0; end

        opa_bytes = a; opa_len_m1 = 4'(la);
        opb_bytes = b; opb_len_m1 = 4'(lb);
        sub_op = sub; start = 1'b1;
        for (int c = 0; c <= lat + 1; c++) begin
            @(negedge clk);
            start = busy_poke && (c == 2);
            if (start) begin
                opa_bytes = mk(128'd1, 0, 4'hC);
                opb_bytes = mk(128'd1, 0, 4'hC);
                opa_len_m1 = '0; opb_len_m1 = '0;
            end
            chk(done == (c == lat), $sformatf("R9 %s done c=%0d", tag, c), 128'(done), 128'(c == lat));
            if (c == lat) begin
                held_res = eres; held_exc = exc; held_ovf = ovf;
                chk(res_bytes == eres, $sformatf("R2 R3 R5 R8 %s result", tag), res_bytes, eres);
                chk(data_exc == exc, $sformatf("R6 %s data_exc", tag), 128'(data_exc), 128'(exc));
                chk(dec_ovf == ovf, $sformatf("R8 %s dec_ovf", tag), 128'(dec_ovf), 128'(ovf));
            end else begin
                chk(res_bytes == held_res && data_exc == held_exc && dec_ovf == held_ovf,
                    $sformatf("R10 %s hold c=%0d", tag, c), res_bytes, held_res);
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] t;
        repeat (5) @(negedge clk);
        chk(done == 0 && data_exc == 0 && dec_ovf == 0 && res_bytes == '0, "R11 reset", res_bytes, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(mk(12345, 2, 4'hC), 2, mk(678, 1, 4'hC), 1, 1'b0, 1'b0, "R1 R2 add");
        run_op(mk(500, 1, 4'hF), 1, mk(200, 1, 4'hA), 1, 1'b1, 1'b0, "R4 sub F/A");
        run_op(mk(1, 0, 4'hC), 0, mk(2, 0, 4'hD), 0, 1'b1, 1'b0, "R2 sub negative");
        run_op(mk(25, 1, 4'hC), 1, mk(1000, 2, 4'hD), 2, 1'b0, 1'b0, "R3 recomplement");
        run_op(mk(777, 1, 4'hB), 1, mk(777, 1, 4'hD), 1, 1'b1, 1'b0, "R3 R5 equal zero");
        run_op(mk(999, 1, 4'hC), 1, mk(1, 0, 4'hC), 0, 1'b0, 1'b0, "R8 carry ovf");
        run_op(mk(5, 0, 4'hC), 0, mk(12345, 2, 4'hE), 2, 1'b0, 1'b0, "R8 long b ovf");
        run_op(mk(3, 0, 4'hD), 0, mk(40, 1, 4'hB), 1, 1'b0, 1'b0, "R8 R4 negative ovf");
        t = mk(123, 1, 4'hC); t[11:8] = 4'hA;
        run_op(t, 1, mk(4, 0, 4'hC), 0, 1'b0, 1'b0, "R6 bad digit");
        run_op(mk(6, 1, 4'hC), 1, mk(5, 0, 4'h9), 0, 1'b0, 1'b0, "R6 bad sign");
        t = mk(7, 0, 4'hC); t[127:8] = '1;
        run_op(t, 0, {{120{1'b1}}, 8'h8C}, 0, 1'b0, 1'b0, "R7 junk add");
        run_op(t, 0, {{120{1'b1}}, 8'h8C}, 0, 1'b1, 1'b0, "R7 junk sub");
        run_op(mk(pow10(31) - 1, 15, 4'hC), 15, mk(1, 0, 4'hC), 0, 1'b0, 1'b0, "R8 max ovf");
        run_op(mk(pow10(31) - 1, 15, 4'hC), 15, mk(pow10(30), 15, 4'hD), 15, 1'b0, 1'b0, "R3 max diff");
        run_op(mk(12345, 2, 4'hC), 2, mk(678, 1, 4'hD), 1, 1'b0, 1'b1, "R10 busy start");
        run_op(mk(9, 0, 4'hC), 0, mk(9, 0, 4'hC), 0, 1'b1, 1'b0, "R5 zero after sub");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule